// File: doc/BRIEF.md
# Real-Mode String Move Address Sequencer

This block produces the memory traffic for a repeated string move in 16-bit real-mode addressing. A single start pulse loads everything it needs: two segment bases, one for the source side and one for the destination side, the two index offsets, an element count, a direction flag and a byte/word select. For each element the block issues two requests. The first is a read at the source physical address. The second is a write at the destination physical address. Each physical address is the segment shifted left four places plus the 16-bit offset, truncated to 20 bits. Once the write is acknowledged, both indices step by the element size, up or down as the direction flag selects, and the count drops by one. When the count runs out, the block raises done. It holds the final index and count values on its outputs until the next start.

The memory side uses a plain request/ready handshake. A request, together with its address and write flag, is held until a cycle in which ready is high. The data path is not part of this block, because only the addresses are sequenced.

The controller has four states:
- **IDLE**: the state after reset.
- **READ**: the source request is issued.
- **WRITE**: the destination request is issued.
- **DONE**: the transfer has finished.

The transitions are:
- IDLE→READ or DONE→READ: start with a non-zero count.
- IDLE→DONE or DONE→DONE: start with a zero count.
- READ→WRITE: read acknowledged.
- WRITE→READ: write acknowledged with more than one element left.
- WRITE→DONE: write acknowledged on the last element.
- Any other cycle: the state is held.

Top module: `rm_string_stepper`

## Requirements
- R1: In READ, mem_req=1, mem_we=0 and mem_addr = ((seg_src<<4) + idx_src) mod 2^20, using the current source index.
- R2: In WRITE, mem_req=1, mem_we=1 and mem_addr = ((seg_dst<<4) + idx_dst) mod 2^20, using the current destination index.
- R3: Every element is a read followed by a write. The cycle after a read is acknowledged (ready=1 while mem_we=0) shows the write request.
- R4: When the write of an element is acknowledged, both indices change by the step size. The step is 1 when word_mode=0 and 2 when word_mode=1. The indices increase when dir_dec=0 and decrease when dir_dec=1.
- R5: The count drops by one per acknowledged write. After exactly cnt_in elements the block stops requesting and raises done.
- R6: A start with cnt_in=0 issues no request, and done=1 in the cycle after start.
- R7: Index arithmetic wraps modulo 2^16. Physical addresses wrap modulo 2^20.
- R8: While a request waits for ready, mem_req, mem_we and mem_addr are held. The index and count outputs change only on an acknowledged write.
- R9: After done, idx_src_out, idx_dst_out and cnt_out hold the final values, and done stays high until the next start.
- R10: After reset, mem_req=0, done=0, busy=0, and the index and count outputs are 0.
- R11: A start pulse while busy=1 is ignored. The transfer in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; loads operands when not busy |
| dir_dec | input | 1 | 1 = indices step down, 0 = step up |
| word_mode | input | 1 | 1 = two-byte elements, 0 = single bytes |
| seg_src | input | 16 | Source segment base |
| seg_dst | input | 16 | Destination segment base |
| idx_src_in | input | 16 | Initial source offset |
| idx_dst_in | input | 16 | Initial destination offset |
| cnt_in | input | 16 | Number of elements |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | 20 | Physical address of the request |
| mem_ready | input | 1 | Acknowledges the current request |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished |
| idx_src_out | output | 16 | Current source offset |
| idx_dst_out | output | 16 | Current destination offset |
| cnt_out | output | 16 | Elements remaining |

## Verification
The bound checker watches several behaviours on every cycle:
- Requests hold steady while ready is low.
- A read acknowledgement is always followed by a write request.
- The count falls by exactly one per write acknowledgement.
- Each index moves by the latched step and direction.
- A zero-count start goes straight to done.
- Done holds the final values, and a start during a transfer is dropped.

The exact 20-bit addresses, including segment and offset wrap-around, can only be shown by the bench's scenarios. The same applies to the total number of elements and the final offsets. The bench compares every request against a model built from the operands it drove.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } step_state_t;
endpackage

// File: rtl/rm_phys_addr.sv
module rm_phys_addr #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = 20
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  pa
);
    logic [PA_W-1:0] base;
    always_comb begin
        base = PA_W'(seg) << SHIFT;
        pa   = base + PA_W'(off);
    end
endmodule

// File: rtl/rm_index_step.sv
module rm_index_step #(
    parameter int OFF_W = 16
) (
    input  logic [OFF_W-1:0] idx,
    input  logic             dec,
    input  logic             wide,
    output logic [OFF_W-1:0] idx_next
);
    logic [OFF_W-1:0] step;
    always_comb begin
        step     = wide ? OFF_W'(2) : OFF_W'(1);
        idx_next = dec ? (idx - step) : (idx + step);
    end
endmodule

// File: rtl/rm_string_stepper.sv
module rm_string_stepper #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int CNT_W = 16,
    parameter int SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_dec,
    input  logic             word_mode,
    input  logic [SEG_W-1:0] seg_src,
    input  logic [SEG_W-1:0] seg_dst,
    input  logic [OFF_W-1:0] idx_src_in,
    input  logic [OFF_W-1:0] idx_dst_in,
    input  logic [CNT_W-1:0] cnt_in,
    output logic             mem_req,
    output logic             mem_we,
    output logic [SEG_W+SHIFT-1:0] mem_addr,
    input  logic             mem_ready,
    output logic             busy,
    output logic             done,
    output logic [OFF_W-1:0] idx_src_out,
    output logic [OFF_W-1:0] idx_dst_out,
    output logic [CNT_W-1:0] cnt_out
);
    import stepper_pkg::*;

    localparam int PA_W = SEG_W + SHIFT;
    localparam int NCH  = 2;   // channel 0 = source, channel 1 = destination

    step_state_t state_q, state_d;

    logic [SEG_W-1:0] seg_q  [NCH];
    logic [OFF_W-1:0] idx_q  [NCH];
    logic [OFF_W-1:0] idx_nx [NCH];
    logic [PA_W-1:0]  pa     [NCH];
    logic [CNT_W-1:0] cnt_q;
    logic             dec_q, wide_q;

    logic accept, wr_ack, last_elem;

    // Per-channel address formation and index stepping
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        rm_phys_addr #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PA_W(PA_W)) u_pa (
            .seg (seg_q[c]),
            .off (idx_q[c]),
            .pa  (pa[c])
        );
        rm_index_step #(.OFF_W(OFF_W)) u_step (
            .idx      (idx_q[c]),
            .dec      (dec_q),
            .wide     (wide_q),
            .idx_next (idx_nx[c])
        );
    end

    assign busy      = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign accept    = start && !busy;
    assign wr_ack    = (state_q == ST_WRITE) && mem_ready;
    assign last_elem = (cnt_q == CNT_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) state_d = (cnt_in == '0) ? ST_DONE : ST_READ;
            end
            ST_READ: begin
                if (mem_ready) state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (mem_ready) state_d = last_elem ? ST_DONE : ST_READ;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Operand registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                seg_q[c] <= '0;
                idx_q[c] <= '0;
            end
            cnt_q  <= '0;
            dec_q  <= 1'b0;
            wide_q <= 1'b0;
        end else if (accept) begin
            seg_q[0] <= seg_src;
            seg_q[1] <= seg_dst;
            idx_q[0] <= idx_src_in;
            idx_q[1] <= idx_dst_in;
            cnt_q    <= cnt_in;
            dec_q    <= dir_dec;
            wide_q   <= word_mode;
        end else if (wr_ack) begin
            for (int c = 0; c < NCH; c++) idx_q[c] <= idx_nx[c];
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Outputs
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = pa[0];
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = pa[1];
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign idx_src_out = idx_q[0];
    assign idx_dst_out = idx_q[1];
    assign cnt_out     = cnt_q;
endmodule

// File: rtl/rm_string_stepper_chk.sv
module rm_string_stepper_chk #(
    parameter int OFF_W = 16,
    parameter int CNT_W = 16,
    parameter int PA_W  = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             dir_dec,
    input logic             word_mode,
    input logic [CNT_W-1:0] cnt_in,
    input logic             mem_req,
    input logic             mem_we,
    input logic [PA_W-1:0]  mem_addr,
    input logic             mem_ready,
    input logic             busy,
    input logic             done,
    input logic [OFF_W-1:0] idx_src_out,
    input logic [OFF_W-1:0] idx_dst_out,
    input logic [CNT_W-1:0] cnt_out
);
    // Step and direction captured independently from accepted starts
    logic             dec_l, wide_l;
    logic [OFF_W-1:0] step_l;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_l  <= 1'b0;
            wide_l <= 1'b0;
        end else if (start && !busy) begin
            dec_l  <= dir_dec;
            wide_l <= word_mode;
        end
    end

    assign step_l = wide_l ? OFF_W'(2) : OFF_W'(1);

    a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we));

    a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    a_r8_state_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(mem_we && mem_ready)) |=>
        ($stable(idx_src_out) && $stable(idx_dst_out) && $stable(cnt_out)));

    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready) |=> (cnt_out == $past(cnt_out) - CNT_W'(1)));

    a_r4_src_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready) |=>
        (idx_src_out == (dec_l ? $past(idx_src_out) - step_l : $past(idx_src_out) + step_l)));

    a_r4_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready) |=>
        (idx_dst_out == (dec_l ? $past(idx_dst_out) - step_l : $past(idx_dst_out) + step_l)));

    a_r6_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cnt_in == '0) |=> (done && !mem_req));

    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=>
        (done && $stable(idx_src_out) && $stable(idx_dst_out) && $stable(cnt_out)));

    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(mem_we && mem_ready)) |=> (busy && $stable(cnt_out)));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && mem_req) && (busy == mem_req));
endmodule

bind rm_string_stepper rm_string_stepper_chk #(
    .OFF_W(OFF_W), .CNT_W(CNT_W), .PA_W(SEG_W + SHIFT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_dec(dir_dec),
    .word_mode(word_mode), .cnt_in(cnt_in), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .busy(busy), .done(done), .idx_src_out(idx_src_out),
    .idx_dst_out(idx_dst_out), .cnt_out(cnt_out)
);

// File: tb/tb_rm_string_stepper.sv
`timescale 1ns/1ps
module tb_rm_string_stepper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_dec = 1'b0;
    logic        word_mode = 1'b0;
    logic [15:0] seg_src = '0, seg_dst = '0;
    logic [15:0] idx_src_in = '0, idx_dst_in = '0, cnt_in = '0;
    logic        mem_ready = 1'b0;
    logic        mem_req, mem_we, busy, done;
    logic [19:0] mem_addr;
    logic [15:0] idx_src_out, idx_dst_out, cnt_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    rm_string_stepper dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_dec(dir_dec),
        .word_mode(word_mode), .seg_src(seg_src), .seg_dst(seg_dst),
        .idx_src_in(idx_src_in), .idx_dst_in(idx_dst_in), .cnt_in(cnt_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .busy(busy), .done(done),
        .idx_src_out(idx_src_out), .idx_dst_out(idx_dst_out), .cnt_out(cnt_out)
    );

    function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
        return ({4'h0, seg} << 4) + {4'h0, off};
    endfunction

    function automatic logic [15:0] nxt(input logic [15:0] idx, input logic dec, input logic wide);
        logic [15:0] st;
        st = wide ? 16'd2 : 16'd1;
        return dec ? idx - st : idx + st;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // One request phase: random wait cycles, then acknowledge.
    task automatic serve(input string tag, input logic we, input logic [19:0] addr,
                         input logic [15:0] s, input logic [15:0] d, input logic [15:0] c);
        int waits;
        waits = int'($urandom_range(0, 3));
        for (int w = 0; w <= waits; w++) begin
            check({tag, " req"}, {31'd0, mem_req}, 32'd1);
            check({tag, " we"}, {31'd0, mem_we}, {31'd0, we});
            check({tag, " addr"}, {12'd0, mem_addr}, {12'd0, addr});
            check("R8 idx/cnt held", {idx_src_out, idx_dst_out}, {s, d});
            check("R8 cnt held", {16'd0, cnt_out}, {16'd0, c});
            mem_ready = (w == waits);
            @(negedge clk);
        end
        mem_ready = 1'b0;
    endtask

    task automatic run_xfer(input logic [15:0] ds, input logic [15:0] es,
                            input logic [15:0] si, input logic [15:0] di,
                            input logic [15:0] cnt, input logic dec, input logic wide,
                            input logic poke);
        logic [15:0] s, d, c;
        s = si; d = di; c = cnt;
        seg_src = ds; seg_dst = es; idx_src_in = si; idx_dst_in = di;
        cnt_in = cnt; dir_dec = dec; word_mode = wide; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (cnt == 16'd0) begin
            check("R6 done at once", {31'd0, done}, 32'd1);
            check("R6 no request", {31'd0, mem_req}, 32'd0);
        end
        for (int k = 0; k < int'(cnt); k++) begin
            if (poke && k == 0) begin
                // R11: start while busy with other operands
                seg_src = ~ds; idx_src_in = ~si; cnt_in = 16'd0; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check("R11 busy kept", {31'd0, busy}, 32'd1);
            end
            serve("R1 read", 1'b0, phys(ds, s), s, d, c);
            serve("R2/R3 write", 1'b1, phys(es, d), s, d, c);
            s = nxt(s, dec, wide);
            d = nxt(d, dec, wide);
            c = c - 16'd1;
        end
        check("R5 done", {31'd0, done}, 32'd1);
        check("R5 no request", {31'd0, mem_req}, 32'd0);
        check("R4/R7 final src", {16'd0, idx_src_out}, {16'd0, s});
        check("R4/R7 final dst", {16'd0, idx_dst_out}, {16'd0, d});
        check("R5 final cnt", {16'd0, cnt_out}, 32'd0);
        repeat (2) @(negedge clk);
        check("R9 done held", {31'd0, done}, 32'd1);
        check("R9 values held", {idx_src_out, idx_dst_out}, {s, d});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1966));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 req", {31'd0, mem_req}, 32'd0);
        check("R10 done", {31'd0, done}, 32'd0);
        check("R10 busy", {31'd0, busy}, 32'd0);
        check("R10 regs", {idx_src_out, idx_dst_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after release", {30'd0, done, mem_req}, 32'd0);

        // Directed corner cases
        run_xfer(16'h1000, 16'h2000, 16'h0010, 16'h0020, 16'd0, 1'b0, 1'b0, 1'b0); // R6
        run_xfer(16'h1234, 16'h4321, 16'h0100, 16'h0200, 16'd3, 1'b0, 1'b0, 1'b0); // R4 byte up
        run_xfer(16'h1234, 16'h4321, 16'h0100, 16'h0200, 16'd3, 1'b1, 1'b1, 1'b0); // R4 word down
        run_xfer(16'hFFFF, 16'hF000, 16'hFFFE, 16'h0001, 16'd3, 1'b0, 1'b1, 1'b0); // R7 wrap
        run_xfer(16'h0001, 16'h0002, 16'h0000, 16'h0001, 16'd3, 1'b1, 1'b0, 1'b0); // R7 wrap down
        run_xfer(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFF0, 16'd2, 1'b0, 1'b0, 1'b0); // R1/R2 2^20 wrap
        run_xfer(16'h0500, 16'h0600, 16'h0004, 16'h0008, 16'd2, 1'b0, 1'b0, 1'b1); // R11

        // Random transfers
        for (int t = 0; t < 40; t++) begin
            run_xfer(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                     16'($urandom_range(0, 6)), 1'($urandom), 1'($urandom), 1'b0);
        end
        finish_run();
    end
endmodule